// File: doc/BRIEF.md
# Gated Auto-Reload Timer with Toggle Output

An 8-bit up-counter that restarts from a programmable reload value each time it passes 0xFF. Each advance of the counter comes either from a small internal prescaler, which divides the system clock by 1, 2, 4 or 8, or from the rising edges of an external clock pin. A gate pin can be enabled so that the counter only advances while the gate is high. Both pins pass through a synchroniser before use.

Each wrap produces a one-cycle interrupt pulse. It can also flip a toggle output, so the output waveform has twice the period of the overflow interval. Software sets the timer up through two write strobes. One writes the reload value. The other writes a control word holding the run, source-select, gate-enable, toggle-enable and divider fields. The live count is visible on an output bus.

Top module: `reload_timer`

## Requirements
- R1: After the counter is loaded with R and started, every advance adds one, and an advance from 0xFF loads the reload register instead, so the count repeats with a period of 256-R advances.
- R2: With ctrl_i bit 1 (source select) at 0, the count advances on the prescaler, where ctrl_i bits 5:4 = s gives one advance every 2^s clocks. The first advance is at the 2^s-th rising edge after the edge that stores run=1.
- R3: With ctrl_i bit 1 at 1, each rising edge of ext_clk_i advances the count by exactly one, provided the pin stays high and low for at least 4 clocks each. The prescaler has no effect in this mode.
- R4: With ctrl_i bit 2 (gate enable) at 1, the count advances only while gate_i is high, seen through a two-clock synchroniser. With the internal divide-by-1 source, the number of advances equals the number of clocks gate_i was high. While gate_i stays low, the count does not change.
- R5: irq_o pulses high for one clock per wrap, in the cycle after the wrapping edge, so the number of high cycles equals the number of wraps.
- R6: With ctrl_i bit 3 (toggle enable) at 1, tgl_o inverts at every wrap. With it at 0, tgl_o stays 0.
- R7: When ctrl_i bit 0 (run) is 0, the count holds, irq_o stays 0, and tgl_o is forced to 0 one clock after run is seen low.
- R8: A write of reload_i while the timer is stopped loads both the reload register and the counter.
- R9: A write of reload_i while the timer is running leaves the count untouched. The new value is first used at the next wrap.
- R10: Asynchronous reset clears the count, the reload value, the control word, irq_o and tgl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reload_we_i | input | 1 | Reload write strobe |
| reload_i | input | 8 | Reload value |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_i | input | 6 | {div_sel[1:0], tgl_en, gate_en, ext_sel, run} |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| gate_i | input | 1 | Gate, high enables counting (asynchronous) |
| count_o | output | 8 | Current count |
| irq_o | output | 1 | Overflow pulse |
| tgl_o | output | 1 | Toggle output |

## Verification
The assertions assume that ext_clk_i and gate_i keep each level for several clocks, so every edge survives the synchroniser. They also assume that write strobes last a single clock. The properties tying irq_o to the reload value rely on the reload register being updated only by reload_we_i. The stimulus holds external clock phases for 4 clocks and changes the gate only on falling clock edges. Every write strobe it issues lasts exactly one cycle. It sweeps several reload values across every divider setting, and predicts count, wraps and toggle state arithmetically.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int DIV_SEL_W = 2;

  typedef struct packed {
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 tgl_en;
    logic                 gate_en;
    logic                 ext_sel;
    logic                 run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rt_sync.sv
module rt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] mask;

  always_comb begin
    span = (CNT_W+1)'(1) << sel_i;
    mask = CNT_W'(span - (CNT_W+1)'(1));
  end

  // phase restarts on every start so the first tick lands at 2^sel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (wrap_o) cnt_q <= reload_i;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_we_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ext_clk_i,
  input  logic              gate_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o,
  output logic              tgl_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic [1:0]       sync_q;
  logic             ext_d_q, ext_rise, presc_tick, gate_ok, src_tick, step, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_q <= '0;
    else if (reload_we_i) reload_q <= reload_i;
  end

  assign run_q = ctrl_q.run;

  rt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({gate_i, ext_clk_i}),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d_q <= 1'b0;
    else         ext_d_q <= sync_q[0];
  end

  assign ext_rise = sync_q[0] & ~ext_d_q;

  rt_prescaler #(.SEL_W(DIV_SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .sel_i  (ctrl_q.div_sel),
    .tick_o (presc_tick)
  );

  assign gate_ok  = ~ctrl_q.gate_en | sync_q[1];
  assign src_tick = ctrl_q.ext_sel ? ext_rise : presc_tick;
  assign step     = run_q & gate_ok & src_tick;

  rt_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (reload_we_i & ~run_q),
    .load_val_i (reload_i),
    .step_i     (step),
    .reload_i   (reload_q),
    .cnt_o      (count_o),
    .wrap_o     (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tgl_o <= 1'b0;
    else if (!run_q)                tgl_o <= 1'b0;
    else if (wrap && ctrl_q.tgl_en) tgl_o <= ~tgl_o;
  end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             reload_we_i,
  input logic [CNT_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             tgl_o
);
  AST_IRQ_SHOWS_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> count_o == $past(reload_q)); // R1

  AST_NO_IRQ_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !irq_o); // R7

  AST_TGL_CLEAR_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !tgl_o); // R7

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !reload_we_i) |=> $stable(count_o)); // R7

  AST_TGL_ONLY_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$stable(tgl_o)) |-> irq_o); // R6

  AST_LOAD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && reload_we_i) |=> count_o == $past(reload_i)); // R8
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_q       (run_q),
  .reload_q    (reload_q),
  .reload_we_i (reload_we_i),
  .reload_i    (reload_i),
  .count_o     (count_o),
  .irq_o       (irq_o),
  .tgl_o       (tgl_o)
);

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reload_we = 1'b0;
  logic [7:0] reload_d = '0;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl_d = '0;
  logic       ext_clk = 1'b0;
  logic       gate = 1'b0;
  logic [7:0] count;
  logic       irq, tgl;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  reload_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reload_we_i(reload_we), .reload_i(reload_d),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl_d), .ext_clk_i(ext_clk), .gate_i(gate),
    .count_o(count), .irq_o(irq), .tgl_o(tgl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] mk(input logic run, input logic ext, input logic gt,
                                    input logic te, input logic [1:0] div);
    return {div, te, gt, ext, run};
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic wr_rel(input logic [7:0] v);
    reload_we = 1'b1; reload_d = v;
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctrl_we = 1'b1; ctrl_d = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic stop_and_check(input logic [5:0] cfg);
    logic [7:0] hold;
    int         hi;
    wr_ctl(cfg & 6'b111110);
    @(negedge clk);
    chk("R7 tgl cleared", tgl, 0);
    hold = count;
    hi = 0;
    repeat (6) begin
      @(negedge clk);
      if (irq) hi++;
    end
    chk("R7 count held", count, hold);
    chk("R7 no irq", hi, 0);
  endtask

  task automatic run_seq(input logic [7:0] r, input int k, input logic te);
    int p, n, t, irqs;
    p = 256 - r;
    n = (1 << k) * (2 * p + 5);
    wr_rel(r);
    chk("R8 load while stopped", count, r);
    wr_ctl(mk(1'b1, 1'b0, 1'b0, te, 2'(k)));
    irqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) irqs++;
    end
    t = n >> k;
    chk("R1 R2 count", count, r + (t % p));
    chk("R5 irq pulses", irqs, t / p);
    chk("R6 toggle", tgl, te ? ((t / p) % 2) : 0);
    stop_and_check(mk(1'b1, 1'b0, 1'b0, te, 2'(k)));
  endtask

  function automatic logic [7:0] rsel(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h80;
      2: return 8'hF0;
      3: return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin : watchdog
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int irqs;
    repeat (3) @(negedge clk);
    chk("R10 count reset", count, 0);
    chk("R10 irq reset", irq, 0);
    chk("R10 tgl reset", tgl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 count after release", count, 0);

    // prescaled source: reload values x divider settings
    for (int ri = 0; ri < 5; ri++)
      for (int k = 0; k < 4; k++)
        run_seq(rsel(ri), k, k[0]);

    // external clock: 6 edges, period 4, prescaler set to /8 (ignored)
    wr_rel(8'hFC);
    wr_ctl(mk(1'b1, 1'b1, 1'b0, 1'b1, 2'd3));
    irqs = 0;
    repeat (6) begin
      ext_clk = 1'b1;
      repeat (4) begin @(negedge clk); if (irq) irqs++; end
      ext_clk = 1'b0;
      repeat (4) begin @(negedge clk); if (irq) irqs++; end
    end
    repeat (4) begin @(negedge clk); if (irq) irqs++; end
    chk("R3 ext count", count, 8'hFE);
    chk("R3 ext wraps", irqs, 1);
    chk("R6 ext toggle", tgl, 1);
    stop_and_check(mk(1'b1, 1'b1, 1'b0, 1'b1, 2'd3));

    // gate
    wr_rel(8'h10);
    wr_ctl(mk(1'b1, 1'b0, 1'b1, 1'b0, 2'd0));
    repeat (20) @(negedge clk);
    chk("R4 gate low holds", count, 8'h10);
    gate = 1'b1;
    repeat (30) @(negedge clk);
    gate = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 gated count", count, 8'h2E);
    stop_and_check(mk(1'b1, 1'b0, 1'b1, 1'b0, 2'd0));

    // reload written while running
    wr_rel(8'hF0);
    wr_ctl(mk(1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    repeat (3) @(negedge clk);
    wr_rel(8'h40);
    chk("R9 count untouched", count, 8'hF4);
    repeat (12) @(negedge clk);
    chk("R9 new reload at wrap", count, 8'h40);
    repeat (4) @(negedge clk);
    chk("R9 counts from new reload", count, 8'h44);
    stop_and_check(mk(1'b1, 1'b0, 1'b0, 1'b0, 2'd0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule